// File: doc/BRIEF.md
# CORDIC Down-Conversion Mixer

This block moves a complex (or real) sample stream down in frequency. A running phase value advances by a programmable tuning word on every accepted sample. Each sample is rotated by the negative of that phase, which multiplies it by a complex exponential at the tuning frequency. A single rotation datapath does the work of both the local oscillator and the complex multiplier, so the block needs no sine table and no multipliers. Every step is a shift and an add.

Each input phase first gets a coarse rotation by a whole number of quarter turns. The remaining angle is always less than a quarter turn, and it is removed by a chain of registered micro-rotations. The input is multiplied by the inverse of the rotation gain using a fixed shift-add sum, so the output keeps the input's scale. The chain is fully pipelined: one sample can enter on every clock. A valid strobe travels through the pipeline alongside the data. The baseband I/Q pair that comes out feeds a decimation chain. To process a real input stream, tie the imaginary input to zero.

Top module: `cordicMixer`

## Requirements
- R1: With phase φ (full turn = 2^PHASE_W), the output is (inI + j·inQ)·e^(−j2πφ/2^PHASE_W) at unity gain: outI = inI·cosθ + inQ·sinθ and outQ = inQ·cosθ − inI·sinθ, each within 2 output LSBs.
- R2: The k-th accepted sample after reset uses the phase held in the accumulator. The accumulator starts at 0 and adds the tuning register on each accepted sample, with no other change. It wraps modulo 2^PHASE_W.
- R3: The tuning register loads tuneWord on a clock edge where tuneLoad is 1, and holds its value otherwise. If a sample is accepted on the same edge as a load, the accumulator step on that edge still uses the old word.
- R4: A sample accepted at rising edge n produces outValid = 1 right after edge n + STAGES + 2. Samples offered on consecutive cycles give outputs on consecutive cycles, one output per input, in order.
- R5: While outValid is 0, outI and outQ keep the values of the last valid output.
- R6: Reset (rstN = 0, synchronous) clears the accumulator, the tuning register and every pipeline valid bit. outValid is 0 during reset, and the first sample after reset passes through with phase 0.
- R7: The two top accumulator bits choose a quarter-turn pre-rotation. With tuning word 2^(PHASE_W−2), successive outputs are (I,Q), (Q,−I), (−I,−Q), (−Q,I).
- R8: With inQ tied to 0, outI = inI·cosθ and outQ = −inI·sinθ.
- R9: Outputs are DATA_W+1 bits wide, so even a full-scale complex input keeps its magnitude without wrap-around. For example, (−32768, −32768) at θ = 45° gives outI = −46341 and outQ = 0.
- R10: On cycles with inValid = 0, the sample inputs are ignored: no output is produced and the phase does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| tuneLoad | input | 1 | Strobe: load tuneWord into the tuning register |
| tuneWord | input | PHASE_W | Phase step per sample (full turn = 2^PHASE_W) |
| inValid | input | 1 | Input sample strobe |
| inI | input | DATA_W | Input real part, two's complement |
| inQ | input | DATA_W | Input imaginary part, two's complement |
| outValid | output | 1 | Output sample strobe |
| outI | output | DATA_W+1 | Baseband real part |
| outQ | output | DATA_W+1 | Baseband imaginary part |

## Verification
A corrupted accumulator or tuning register does not stay hidden. It shows up as a wrong rotation angle on every later output, starting with the first sample that leaves the pipeline STAGES+3 cycles after the fault. A wrong micro-rotation direction or a wrong arctangent constant leaves a magnitude or angle error larger than the 2-LSB tolerance on that same sample. A broken valid pipeline shows up as a strobe that is missing, extra, or at the wrong edge, and the cycle-exact latency check catches it. Quarter-turn steps and the full-scale corner expose errors in the quadrant selection and in the width and gain handling.

// File: rtl/cordicMixPkg.sv
package cordicMixPkg;

  // Per-cycle strobes from the control to the datapath.
  typedef struct packed {
    logic loadIn;   // capture the input sample and its phase
    logic loadOut;  // last micro-rotation holds a valid sample
  } mixStrobeT;

  // arctan(2^-k) expressed as a fraction of a full turn, scaled by 2^32.
  function automatic logic [31:0] atanTurn(input int k);
    case (k)
      0:  atanTurn = 32'h20000000;
      1:  atanTurn = 32'h12E4051E;
      2:  atanTurn = 32'h09FB385B;
      3:  atanTurn = 32'h051111D4;
      4:  atanTurn = 32'h028B0D43;
      5:  atanTurn = 32'h0145D7E1;
      6:  atanTurn = 32'h00A2F61E;
      7:  atanTurn = 32'h00517C55;
      8:  atanTurn = 32'h0028BE53;
      9:  atanTurn = 32'h00145F2F;
      10: atanTurn = 32'h000A2F98;
      11: atanTurn = 32'h000517CC;
      12: atanTurn = 32'h00028BE6;
      13: atanTurn = 32'h000145F3;
      14: atanTurn = 32'h0000A2FA;
      15: atanTurn = 32'h0000517D;
      16: atanTurn = 32'h000028BE;
      17: atanTurn = 32'h0000145F;
      18: atanTurn = 32'h00000A30;
      19: atanTurn = 32'h00000518;
      20: atanTurn = 32'h0000028C;
      21: atanTurn = 32'h00000146;
      22: atanTurn = 32'h000000A3;
      23: atanTurn = 32'h00000051;
      default: atanTurn = 32'h0;
    endcase
  endfunction

endpackage

// File: rtl/mixCtl.sv
module mixCtl
  import cordicMixPkg::*;
#(
  parameter int PHASE_W = 32,
  parameter int STAGES  = 18
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tuneLoad,
  input  logic [PHASE_W-1:0] tuneWord,
  input  logic               inValid,
  output mixStrobeT          stb,
  output logic [PHASE_W-1:0] phaseCur,
  output logic               outValid
);

  // valid bits: input reg, pre-rotation reg, STAGES rotations, output reg
  localparam int VLD_LEN = STAGES + 3;
  localparam int CNT_W   = $clog2(VLD_LEN + 1) + 1;

  logic [PHASE_W-1:0] tuneReg;
  logic [PHASE_W-1:0] phaseAcc;
  logic [VLD_LEN-1:0] vldPipe;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tuneReg  <= '0;
      phaseAcc <= '0;
      vldPipe  <= '0;
    end else begin
      if (tuneLoad) tuneReg <= tuneWord;
      if (inValid)  phaseAcc <= phaseAcc + tuneReg;
      vldPipe <= {vldPipe[VLD_LEN-2:0], inValid};
    end
  end

  assign phaseCur    = phaseAcc;
  assign stb.loadIn  = inValid;
  assign stb.loadOut = vldPipe[VLD_LEN-2];
  assign outValid    = vldPipe[VLD_LEN-1];

  // Independent count of samples inside the pipeline, for checking only.
  logic [CNT_W-1:0] inFlight;
  always_ff @(posedge clk) begin
    if (!rstN) inFlight <= '0;
    else       inFlight <= inFlight + CNT_W'(inValid) - CNT_W'(outValid);
  end

  AST_VALID_CONSERVED: assert property (@(posedge clk) disable iff (!rstN)
    inFlight == CNT_W'($countones(vldPipe))); // R4
  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(phaseAcc)); // R10
  AST_TUNE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !tuneLoad |=> $stable(tuneReg)); // R3

endmodule

// File: rtl/mixPath.sv
module mixPath
  import cordicMixPkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int PHASE_W = 32,
  parameter int STAGES  = 18,
  parameter int GUARD_W = 6
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  mixStrobeT                 stb,
  input  logic [PHASE_W-1:0]        phaseCur,
  input  logic signed [DATA_W-1:0]  inI,
  input  logic signed [DATA_W-1:0]  inQ,
  output logic signed [DATA_W:0]    outI,
  output logic signed [DATA_W:0]    outQ
);

  // internal width: sample + guard bits + growth headroom + sign
  localparam int IW = DATA_W + GUARD_W + 2;
  localparam logic signed [IW-1:0] RND = IW'(1) <<< (GUARD_W - 1);

  function automatic logic signed [PHASE_W-1:0] stepAng(input int k);
    stepAng = PHASE_W'(atanTurn(k) >> (32 - PHASE_W));
  endfunction

  localparam logic signed [PHASE_W-1:0] Z_BOUND = PHASE_W'(2 * (atanTurn(STAGES-1) >> (32 - PHASE_W)));

  // multiply by ~0.607253 (inverse rotation gain) with shift-add terms
  function automatic logic signed [IW-1:0] gainComp(input logic signed [IW-1:0] v);
    gainComp = (v >>> 1) + (v >>> 3) - (v >>> 6) - (v >>> 9)
             - (v >>> 13) - (v >>> 15) - (v >>> 16) - (v >>> 20);
  endfunction

  // input register: sample and negated phase (down-conversion)
  logic signed [DATA_W-1:0] aI, aQ;
  logic [PHASE_W-1:0]       aAng;

  always_ff @(posedge clk) begin
    if (stb.loadIn) begin
      aI   <= inI;
      aQ   <= inQ;
      aAng <= -phaseCur;
    end
  end

  // quarter-turn pre-rotation chosen by the two top angle bits
  logic signed [IW-1:0]      wI, wQ, rI, rQ, bX, bY;
  logic signed [PHASE_W-1:0] bZ;

  always_comb begin
    wI = IW'(aI) <<< GUARD_W;
    wQ = IW'(aQ) <<< GUARD_W;
    case (aAng[PHASE_W-1 -: 2])
      2'd0:    begin rI = wI;  rQ = wQ;  end
      2'd1:    begin rI = -wQ; rQ = wI;  end
      2'd2:    begin rI = -wI; rQ = -wQ; end
      default: begin rI = wQ;  rQ = -wI; end
    endcase
    bX = gainComp(rI);
    bY = gainComp(rQ);
    bZ = {2'b00, aAng[PHASE_W-3:0]};
  end

  // micro-rotation chain; element 0 is the pre-rotated, scaled sample
  logic signed [IW-1:0]      xs [0:STAGES];
  logic signed [IW-1:0]      ys [0:STAGES];
  logic signed [PHASE_W-1:0] zs [0:STAGES];

  always_ff @(posedge clk) begin
    xs[0] <= bX;
    ys[0] <= bY;
    zs[0] <= bZ;
    for (int k = 0; k < STAGES; k++) begin
      if (zs[k][PHASE_W-1]) begin
        xs[k+1] <= xs[k] + (ys[k] >>> k);
        ys[k+1] <= ys[k] - (xs[k] >>> k);
        zs[k+1] <= zs[k] + stepAng(k);
      end else begin
        xs[k+1] <= xs[k] - (ys[k] >>> k);
        ys[k+1] <= ys[k] + (xs[k] >>> k);
        zs[k+1] <= zs[k] - stepAng(k);
      end
    end
  end

  // round away the guard bits into the output register
  always_ff @(posedge clk) begin
    if (stb.loadOut) begin
      outI <= (DATA_W+1)'((xs[STAGES] + RND) >>> GUARD_W);
      outQ <= (DATA_W+1)'((ys[STAGES] + RND) >>> GUARD_W);
    end
  end

  AST_RESIDUAL_CONVERGED: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadOut |-> (zs[STAGES] <= Z_BOUND) && (zs[STAGES] >= -Z_BOUND)); // R1
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadOut |-> (xs[STAGES][IW-1] == xs[STAGES][IW-2]) &&
                    (ys[STAGES][IW-1] == ys[STAGES][IW-2])); // R9
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !stb.loadOut |=> $stable(outI) && $stable(outQ)); // R5

endmodule

// File: rtl/cordicMixer.sv
module cordicMixer #(
  parameter int DATA_W  = 16,
  parameter int PHASE_W = 32,
  parameter int STAGES  = 18,
  parameter int GUARD_W = 6
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     tuneLoad,
  input  logic [PHASE_W-1:0]       tuneWord,
  input  logic                     inValid,
  input  logic signed [DATA_W-1:0] inI,
  input  logic signed [DATA_W-1:0] inQ,
  output logic                     outValid,
  output logic signed [DATA_W:0]   outI,
  output logic signed [DATA_W:0]   outQ
);

  cordicMixPkg::mixStrobeT stb;
  logic [PHASE_W-1:0]      phaseCur;

  mixCtl #(
    .PHASE_W (PHASE_W),
    .STAGES  (STAGES)
  ) ctl (
    .clk      (clk),
    .rstN     (rstN),
    .tuneLoad (tuneLoad),
    .tuneWord (tuneWord),
    .inValid  (inValid),
    .stb      (stb),
    .phaseCur (phaseCur),
    .outValid (outValid)
  );

  mixPath #(
    .DATA_W  (DATA_W),
    .PHASE_W (PHASE_W),
    .STAGES  (STAGES),
    .GUARD_W (GUARD_W)
  ) path (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .phaseCur (phaseCur),
    .inI      (inI),
    .inQ      (inQ),
    .outI     (outI),
    .outQ     (outQ)
  );

endmodule

// File: tb/cordicMixer_test.sv
module cordicMixer_test;

  localparam int    DW     = 16;
  localparam int    PW     = 32;
  localparam int    STG    = 18;
  localparam real   PI     = 3.14159265358979;
  localparam real   TOL    = 2.0;

  logic                 clk = 0;
  logic                 rstN = 0;
  logic                 tuneLoad = 0;
  logic [PW-1:0]        tuneWord = '0;
  logic                 inValid = 0;
  logic signed [DW-1:0] inI = '0, inQ = '0;
  logic                 outValid;
  logic signed [DW:0]   outI, outQ;

  cordicMixer #(.DATA_W(DW), .PHASE_W(PW), .STAGES(STG), .GUARD_W(6)) uut (
    .clk(clk), .rstN(rstN), .tuneLoad(tuneLoad), .tuneWord(tuneWord),
    .inValid(inValid), .inI(inI), .inQ(inQ),
    .outValid(outValid), .outI(outI), .outQ(outQ)
  );

  always #2 clk = ~clk;  // 250 MHz

  int checks = 0, errors = 0, edgeCnt = 0;
  bit finished = 0;
  always @(posedge clk) edgeCnt <= edgeCnt + 1;

  // scoreboard
  real   qI[$], qQ[$];
  int    qE[$];
  string qT[$];
  logic [PW-1:0] modelAcc = '0, modelTune = '0;
  bit haveLast = 0;
  int lastI = 0, lastQ = 0;

  task automatic check(input bit ok, input string tag, input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s", tag, what);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // driver: offer one sample (optionally with a tuning load on the same edge)
  task automatic sendSample(input int xi, input int xq, input bit doLoad,
                            input logic [PW-1:0] w, input string tag);
    real th;
    @(negedge clk);
    inValid  = 1;
    inI      = DW'(xi);
    inQ      = DW'(xq);
    tuneLoad = doLoad;
    tuneWord = w;
    th = 2.0 * PI * real'(modelAcc) / 4294967296.0;
    qI.push_back(real'(xi) * $cos(th) + real'(xq) * $sin(th));
    qQ.push_back(real'(xq) * $cos(th) - real'(xi) * $sin(th));
    qE.push_back(edgeCnt + 1 + STG + 2);
    qT.push_back(tag);
    modelAcc = modelAcc + modelTune;  // step uses the old word (R3)
    if (doLoad) modelTune = w;
  endtask

  task automatic loadTune(input logic [PW-1:0] w);
    @(negedge clk);
    inValid  = 0;
    tuneLoad = 1;
    tuneWord = w;
    modelTune = w;
  endtask

  // idle cycles with junk on the data and tuning inputs
  task automatic idle(input int n, input bit quiet);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid  = 0;
      tuneLoad = 0;
      inI      = DW'($urandom);
      inQ      = DW'($urandom);
      tuneWord = $urandom;
      if (quiet)
        check(outValid == 1'b0, "R10",
              $sformatf("outValid during ignored input actual %0b expected 0", outValid));
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 0; inValid = 0; tuneLoad = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(outValid == 1'b0, "R6",
            $sformatf("outValid in reset actual %0b expected 0", outValid));
    end
    rstN = 1;
    modelAcc = '0;
    modelTune = '0;
  endtask

  // monitor: compare each output with the head of the scoreboard
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (qI.size() == 0) begin
        check(0, "R10", "outValid with nothing pending actual 1 expected 0");
      end else begin
        automatic real   eI = qI.pop_front();
        automatic real   eQ = qQ.pop_front();
        automatic int    eE = qE.pop_front();
        automatic string tg = qT.pop_front();
        automatic int    aI = int'(outI);
        automatic int    aQ = int'(outQ);
        check(edgeCnt == eE, "R4",
              $sformatf("output edge actual %0d expected %0d", edgeCnt, eE));
        check((real'(aI) - eI <= TOL) && (eI - real'(aI) <= TOL), tg,
              $sformatf("outI actual %0d expected %0.2f", aI, eI));
        check((real'(aQ) - eQ <= TOL) && (eQ - real'(aQ) <= TOL), tg,
              $sformatf("outQ actual %0d expected %0.2f", aQ, eQ));
        lastI = aI; lastQ = aQ; haveLast = 1;
      end
    end else if (rstN && haveLast) begin
      check(int'(outI) == lastI && int'(outQ) == lastQ, "R5",
            $sformatf("held output actual (%0d,%0d) expected (%0d,%0d)",
                      int'(outI), int'(outQ), lastI, lastQ));
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "R4", "watchdog expired actual running expected done");
    finishRun();
  end

  initial begin
    doReset();                                   // R6
    idle(3, 1);
    sendSample(1000, -2000, 0, '0, "R6");        // phase 0 after reset
    // quarter turns: 0, 90, 180, 270 degrees (R7)
    loadTune(32'h40000000);
    for (int i = 0; i < 4; i++) sendSample(12000, 5000, 0, '0, "R7");
    idle(30, 0);
    idle(10, 1);                                 // R10: junk ignored
    sendSample(7000, -3000, 0, '0, "R10");       // phase must not have moved
    // R3: load a new word on the same edge as a sample
    sendSample(-9000, 4000, 1, 32'h0A3D70A4, "R3");
    sendSample(-9000, 4000, 0, '0, "R3");
    sendSample(-9000, 4000, 0, '0, "R3");
    // R1/R2/R4: back-to-back varied complex samples
    for (int i = 0; i < 40; i++)
      sendSample((i * 1733) % 30000 - 15000, 20000 - (i * 977) % 40000, 0, '0, "R1");
    loadTune(32'hF3A1C2B7);                      // negative-frequency step, wraps (R2)
    for (int i = 0; i < 20; i++)
      sendSample(25000 - i * 2100, -i * 1500, 0, '0, "R2");
    // R8: real input
    loadTune(32'h12345678);
    for (int i = 0; i < 12; i++) sendSample(30000 - i * 4000, 0, 0, '0, "R8");
    idle(30, 0);
    // R9: full scale after a fresh reset, 45-degree steps
    doReset();
    loadTune(32'h20000000);
    sendSample(-32768, -32768, 0, '0, "R9");
    sendSample(-32768, -32768, 0, '0, "R9");     // expects (-46341, 0)
    sendSample(32767, 32767, 0, '0, "R9");
    sendSample(32767, -32768, 0, '0, "R9");
    sendSample(-32768, 32767, 0, '0, "R9");
    idle(30, 0);
    check(qI.size() == 0, "R4",
          $sformatf("pending outputs actual %0d expected 0", qI.size()));
    finishRun();
  end

endmodule